// File: doc/BRIEF.md
# Ring Data Mover with Read Merging

This block is the data movement unit of one compute group on a one-way chain of groups. Frames arrive from the upstream neighbour, are unpacked, and are either used locally (delivered to all local cores, or written into the local shared buffer), passed on unchanged to the downstream neighbour, or both. Local cores also issue read requests to off-chip memory. Requests with the same address and length that arrive in the same cycle are combined into one memory read, and each returned beat goes out to every core in that merged group through a core bitmask.

A configuration frame addressed to this group turns on onward forwarding of memory read data. Each returned beat is then also packed into a forward frame for the downstream link. A core's save output goes either to the local shared buffer or to off-chip memory. Upstream link traffic has priority over memory responses and local saves wherever they share a path. Downstream backpressure holds local delivery of the same beat, so no beat is lost.

Top module: `ring_mover`

## Requirements
- R1: After reset no memory read is offered, the downstream link is idle, no core is driven and `up_ready_o` is high with idle inputs; forwarding of memory data starts disabled, so response beats never appear downstream until it is enabled.
- R2: In a cycle with no read outstanding, every requesting core whose address and length both equal those of the lowest-index requester is granted in that cycle (`rd_gnt_o`), and exactly one memory read with that address and length is offered from the next cycle until `mem_rd_ready_i`.
- R3: A requesting core whose address or length differs from the lowest-index requester is not granted in that cycle; it keeps requesting and is granted in a later idle cycle.
- R4: Each accepted response beat appears on `core_data_o` in the cycle it is accepted, with `core_valid_o` equal to the granted mask; the beat with `mem_rsp_last_i` high ends the read.
- R5: Only one read is outstanding: no grant is given and no new read is offered from the grant until the last response beat is accepted.
- R6: A frame is {kind[1:0], dest[GID_W-1:0], tag[ADDR_W-1:0], payload[DATA_W-1:0]} from MSB to LSB, with kind 0 = load, 1 = save, 2 = forward, 3 = config.
- R7: A frame whose dest differs from GROUP_ID goes downstream unchanged; a load frame to this group is delivered to all cores and not forwarded; a forward frame is delivered to all cores and also forwarded unless its dest equals GROUP_ID.
- R8: While a frame that must be forwarded waits for `dn_ready_i`, `up_ready_o` is low and it is not delivered locally; both happen in the cycle downstream accepts.
- R9: A save frame to this group writes its payload to the shared buffer at its tag; a core save goes to off-chip memory when `sv_to_mem_i` is high and to the shared buffer otherwise, and a same-cycle save frame wins the buffer port, holding `sv_ready_o` low.
- R10: A config frame to this group is consumed (not forwarded, not delivered); payload bit 0 enables forwarding of memory data and payload bits [GID_W:1] set the dest; when enabled each response beat is also sent downstream as {forward, dest, read address, data} and is accepted and delivered locally only in a cycle downstream accepts.
- R11: A memory response beat is held (`mem_rsp_ready_o` low) in any cycle an upstream frame is delivered locally or is offered downstream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_req_i | input | NCORE | Per-core read request, held until granted |
| rd_addr_i | input | NCORE*ADDR_W | Per-core read address, core 0 in the low bits |
| rd_len_i | input | NCORE*LEN_W | Per-core read length |
| rd_gnt_o | output | NCORE | Per-core grant, one cycle |
| mem_rd_valid_o | output | 1 | Merged read offered to memory |
| mem_rd_ready_i | input | 1 | Memory accepts the read |
| mem_rd_addr_o | output | ADDR_W | Merged read address |
| mem_rd_len_o | output | LEN_W | Merged read length |
| mem_rsp_valid_i | input | 1 | Response beat valid |
| mem_rsp_ready_o | output | 1 | Response beat accepted |
| mem_rsp_data_i | input | DATA_W | Response beat data |
| mem_rsp_last_i | input | 1 | Last beat of the read |
| core_valid_o | output | NCORE | Cores receiving `core_data_o` this cycle |
| core_data_o | output | DATA_W | Data delivered to cores |
| sv_valid_i | input | 1 | Core save valid |
| sv_ready_o | output | 1 | Core save accepted |
| sv_to_mem_i | input | 1 | Save target: 1 off-chip, 0 shared buffer |
| sv_addr_i | input | ADDR_W | Save address |
| sv_data_i | input | DATA_W | Save data |
| buf_we_o | output | 1 | Shared buffer write enable |
| buf_addr_o | output | ADDR_W | Shared buffer address |
| buf_wdata_o | output | DATA_W | Shared buffer write data |
| mem_wr_valid_o | output | 1 | Off-chip write valid |
| mem_wr_ready_i | input | 1 | Off-chip write accepted |
| mem_wr_addr_o | output | ADDR_W | Off-chip write address |
| mem_wr_data_o | output | DATA_W | Off-chip write data |
| up_valid_i | input | 1 | Upstream frame valid |
| up_ready_o | output | 1 | Upstream frame accepted |
| up_frame_i | input | FRAME_W | Upstream frame |
| dn_valid_o | output | 1 | Downstream frame valid |
| dn_ready_i | input | 1 | Downstream accepts |
| dn_frame_o | output | FRAME_W | Downstream frame |

## Verification
The bench builds the block with four cores, GID_W of 3, ADDR_W of 8, LEN_W of 4, DATA_W of 16 and GROUP_ID of 2. Random read addresses come from a pool of three values and lengths from two, so same-cycle duplicates, partial matches and lone requesters all occur often. Random frame destinations fall in 0 to 3, so about one frame in four targets this group, and random downstream stalls reach the backpressure path. The narrow data width still leaves room above GID_W for the config payload fields.

// File: rtl/ring_mover_pkg.sv
package ring_mover_pkg;

  typedef enum logic [1:0] {
    FT_LOAD = 2'd0,
    FT_SAVE = 2'd1,
    FT_FWD  = 2'd2,
    FT_CFG  = 2'd3
  } frame_kind_e;

  typedef enum logic [1:0] {
    RM_IDLE  = 2'd0,
    RM_ISSUE = 2'd1,
    RM_WAIT  = 2'd2
  } merge_state_e;

endpackage

// File: rtl/rm_read_merge.sv
module rm_read_merge
  import ring_mover_pkg::*;
#(
  parameter int NCORE  = 4,
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NCORE-1:0]        rd_req_i,
  input  logic [NCORE*ADDR_W-1:0] rd_addr_i,
  input  logic [NCORE*LEN_W-1:0]  rd_len_i,
  output logic [NCORE-1:0]        rd_gnt_o,
  output logic                    mem_rd_valid_o,
  input  logic                    mem_rd_ready_i,
  output logic [ADDR_W-1:0]       mem_rd_addr_o,
  output logic [LEN_W-1:0]        mem_rd_len_o,
  input  logic                    rsp_done_i,
  output logic                    rsp_open_o,
  output logic [NCORE-1:0]        pend_mask_o
);

  merge_state_e state_q;
  logic [ADDR_W-1:0] addr_a [NCORE];
  logic [LEN_W-1:0]  len_a  [NCORE];
  logic [NCORE-1:0]  match;
  logic [ADDR_W-1:0] lead_addr, addr_q;
  logic [LEN_W-1:0]  lead_len, len_q;
  logic [NCORE-1:0]  mask_q;

  for (genvar g = 0; g < NCORE; g++) begin : g_core
    assign addr_a[g] = rd_addr_i[g*ADDR_W +: ADDR_W];
    assign len_a[g]  = rd_len_i[g*LEN_W +: LEN_W];
    assign match[g]  = rd_req_i[g] && (addr_a[g] == lead_addr) && (len_a[g] == lead_len);
  end

  // lowest index requester sets the merge key
  always_comb begin
    lead_addr = '0;
    lead_len  = '0;
    for (int i = NCORE - 1; i >= 0; i--) begin
      if (rd_req_i[i]) begin
        lead_addr = addr_a[i];
        lead_len  = len_a[i];
      end
    end
  end

  assign rd_gnt_o       = (state_q == RM_IDLE) ? match : '0;
  assign mem_rd_valid_o = (state_q == RM_ISSUE);
  assign mem_rd_addr_o  = addr_q;
  assign mem_rd_len_o   = len_q;
  assign rsp_open_o     = (state_q == RM_WAIT);
  assign pend_mask_o    = mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RM_IDLE;
      addr_q  <= '0;
      len_q   <= '0;
      mask_q  <= '0;
    end else begin
      unique case (state_q)
        RM_IDLE: if (|match) begin
          state_q <= RM_ISSUE;
          addr_q  <= lead_addr;
          len_q   <= lead_len;
          mask_q  <= match;
        end
        RM_ISSUE: if (mem_rd_ready_i) state_q <= RM_WAIT;
        RM_WAIT:  if (rsp_done_i) state_q <= RM_IDLE;
        default:  state_q <= RM_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rm_link_steer.sv
module rm_link_steer
  import ring_mover_pkg::*;
#(
  parameter int NCORE    = 4,
  parameter int GID_W    = 3,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int GROUP_ID = 0,
  parameter int FRAME_W  = 2 + GID_W + ADDR_W + DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               up_valid_i,
  output logic               up_ready_o,
  input  logic [FRAME_W-1:0] up_frame_i,
  output logic               dn_valid_o,
  input  logic               dn_ready_i,
  output logic [FRAME_W-1:0] dn_frame_o,
  input  logic               mem_rsp_valid_i,
  output logic               mem_rsp_ready_o,
  input  logic [DATA_W-1:0]  mem_rsp_data_i,
  input  logic               mem_rsp_last_i,
  input  logic               rsp_open_i,
  input  logic [NCORE-1:0]   pend_mask_i,
  input  logic [ADDR_W-1:0]  pend_addr_i,
  output logic               rsp_done_o,
  output logic [NCORE-1:0]   core_valid_o,
  output logic [DATA_W-1:0]  core_data_o,
  output logic               up_buf_we_o,
  output logic [ADDR_W-1:0]  up_buf_addr_o,
  output logic [DATA_W-1:0]  up_buf_data_o
);

  localparam int TAG_LSB  = DATA_W;
  localparam int DST_LSB  = TAG_LSB + ADDR_W;
  localparam int KIND_LSB = DST_LSB + GID_W;
  localparam logic [GID_W-1:0] MY_ID = GID_W'(GROUP_ID);

  frame_kind_e       up_kind;
  logic [GID_W-1:0]  up_dst;
  logic [ADDR_W-1:0] up_tag;
  logic [DATA_W-1:0] up_pay;
  logic mine, up_fwd, up_loc, up_sav, up_cfg, up_fire, rsp_fire, rsp_fwd;
  logic              fwd_en_q;
  logic [GID_W-1:0]  fwd_dst_q;

  // unpack
  assign up_kind = frame_kind_e'(up_frame_i[KIND_LSB +: 2]);
  assign up_dst  = up_frame_i[DST_LSB +: GID_W];
  assign up_tag  = up_frame_i[TAG_LSB +: ADDR_W];
  assign up_pay  = up_frame_i[DATA_W-1:0];

  // decode into steering selects
  assign mine   = (up_dst == MY_ID);
  assign up_fwd = up_valid_i && !mine;
  assign up_loc = up_valid_i && ((up_kind == FT_LOAD && mine) || up_kind == FT_FWD);
  assign up_sav = up_valid_i && up_kind == FT_SAVE && mine;
  assign up_cfg = up_valid_i && up_kind == FT_CFG && mine;

  assign up_ready_o = !up_fwd || dn_ready_i;
  assign up_fire    = up_valid_i && up_ready_o;

  // upstream owns the core bus and the link when it needs them
  assign rsp_fwd         = rsp_open_i && mem_rsp_valid_i && fwd_en_q && !up_loc && !up_fwd;
  assign mem_rsp_ready_o = rsp_open_i && !up_loc && !up_fwd && (!fwd_en_q || dn_ready_i);
  assign rsp_fire        = mem_rsp_valid_i && mem_rsp_ready_o;
  assign rsp_done_o      = rsp_fire && mem_rsp_last_i;

  always_comb begin
    dn_valid_o = 1'b0;
    dn_frame_o = '0;
    if (up_fwd) begin
      dn_valid_o = 1'b1;
      dn_frame_o = up_frame_i;
    end else if (rsp_fwd) begin
      dn_valid_o = 1'b1;
      dn_frame_o = {FT_FWD, fwd_dst_q, pend_addr_i, mem_rsp_data_i};
    end
  end

  always_comb begin
    core_valid_o = '0;
    core_data_o  = '0;
    if (up_loc && up_fire) begin
      core_valid_o = '1;
      core_data_o  = up_pay;
    end else if (rsp_fire) begin
      core_valid_o = pend_mask_i;
      core_data_o  = mem_rsp_data_i;
    end
  end

  assign up_buf_we_o   = up_sav;
  assign up_buf_addr_o = up_tag;
  assign up_buf_data_o = up_pay;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_en_q  <= 1'b0;
      fwd_dst_q <= '0;
    end else if (up_cfg) begin
      fwd_en_q  <= up_pay[0];
      fwd_dst_q <= up_pay[GID_W:1];
    end
  end

endmodule

// File: rtl/rm_save_route.sv
module rm_save_route #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              up_buf_we_i,
  input  logic [ADDR_W-1:0] up_buf_addr_i,
  input  logic [DATA_W-1:0] up_buf_data_i,
  input  logic              sv_valid_i,
  output logic              sv_ready_o,
  input  logic              sv_to_mem_i,
  input  logic [ADDR_W-1:0] sv_addr_i,
  input  logic [DATA_W-1:0] sv_data_i,
  output logic              buf_we_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [DATA_W-1:0] buf_wdata_o,
  output logic              mem_wr_valid_o,
  input  logic              mem_wr_ready_i,
  output logic [ADDR_W-1:0] mem_wr_addr_o,
  output logic [DATA_W-1:0] mem_wr_data_o
);

  logic loc_buf;

  assign loc_buf     = sv_valid_i && !sv_to_mem_i && !up_buf_we_i;
  assign buf_we_o    = up_buf_we_i || loc_buf;
  assign buf_addr_o  = up_buf_we_i ? up_buf_addr_i : sv_addr_i;
  assign buf_wdata_o = up_buf_we_i ? up_buf_data_i : sv_data_i;

  assign mem_wr_valid_o = sv_valid_i && sv_to_mem_i;
  assign mem_wr_addr_o  = sv_addr_i;
  assign mem_wr_data_o  = sv_data_i;

  assign sv_ready_o = sv_to_mem_i ? mem_wr_ready_i : !up_buf_we_i;

endmodule

// File: rtl/ring_mover.sv
module ring_mover #(
  parameter int NCORE    = 4,
  parameter int GID_W    = 3,
  parameter int ADDR_W   = 16,
  parameter int LEN_W    = 4,
  parameter int DATA_W   = 32,
  parameter int GROUP_ID = 0,
  parameter int FRAME_W  = 2 + GID_W + ADDR_W + DATA_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NCORE-1:0]        rd_req_i,
  input  logic [NCORE*ADDR_W-1:0] rd_addr_i,
  input  logic [NCORE*LEN_W-1:0]  rd_len_i,
  output logic [NCORE-1:0]        rd_gnt_o,
  output logic                    mem_rd_valid_o,
  input  logic                    mem_rd_ready_i,
  output logic [ADDR_W-1:0]       mem_rd_addr_o,
  output logic [LEN_W-1:0]        mem_rd_len_o,
  input  logic                    mem_rsp_valid_i,
  output logic                    mem_rsp_ready_o,
  input  logic [DATA_W-1:0]       mem_rsp_data_i,
  input  logic                    mem_rsp_last_i,
  output logic [NCORE-1:0]        core_valid_o,
  output logic [DATA_W-1:0]       core_data_o,
  input  logic                    sv_valid_i,
  output logic                    sv_ready_o,
  input  logic                    sv_to_mem_i,
  input  logic [ADDR_W-1:0]       sv_addr_i,
  input  logic [DATA_W-1:0]       sv_data_i,
  output logic                    buf_we_o,
  output logic [ADDR_W-1:0]       buf_addr_o,
  output logic [DATA_W-1:0]       buf_wdata_o,
  output logic                    mem_wr_valid_o,
  input  logic                    mem_wr_ready_i,
  output logic [ADDR_W-1:0]       mem_wr_addr_o,
  output logic [DATA_W-1:0]       mem_wr_data_o,
  input  logic                    up_valid_i,
  output logic                    up_ready_o,
  input  logic [FRAME_W-1:0]      up_frame_i,
  output logic                    dn_valid_o,
  input  logic                    dn_ready_i,
  output logic [FRAME_W-1:0]      dn_frame_o
);

  logic              rsp_done, rsp_open;
  logic [NCORE-1:0]  pend_mask;
  logic              up_buf_we;
  logic [ADDR_W-1:0] up_buf_addr;
  logic [DATA_W-1:0] up_buf_data;

  rm_read_merge #(
    .NCORE (NCORE),
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W)
  ) u_merge (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .rd_req_i       (rd_req_i),
    .rd_addr_i      (rd_addr_i),
    .rd_len_i       (rd_len_i),
    .rd_gnt_o       (rd_gnt_o),
    .mem_rd_valid_o (mem_rd_valid_o),
    .mem_rd_ready_i (mem_rd_ready_i),
    .mem_rd_addr_o  (mem_rd_addr_o),
    .mem_rd_len_o   (mem_rd_len_o),
    .rsp_done_i     (rsp_done),
    .rsp_open_o     (rsp_open),
    .pend_mask_o    (pend_mask)
  );

  rm_link_steer #(
    .NCORE   (NCORE),
    .GID_W   (GID_W),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .GROUP_ID(GROUP_ID),
    .FRAME_W (FRAME_W)
  ) u_steer (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .up_valid_i      (up_valid_i),
    .up_ready_o      (up_ready_o),
    .up_frame_i      (up_frame_i),
    .dn_valid_o      (dn_valid_o),
    .dn_ready_i      (dn_ready_i),
    .dn_frame_o      (dn_frame_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_ready_o (mem_rsp_ready_o),
    .mem_rsp_data_i  (mem_rsp_data_i),
    .mem_rsp_last_i  (mem_rsp_last_i),
    .rsp_open_i      (rsp_open),
    .pend_mask_i     (pend_mask),
    .pend_addr_i     (mem_rd_addr_o),
    .rsp_done_o      (rsp_done),
    .core_valid_o    (core_valid_o),
    .core_data_o     (core_data_o),
    .up_buf_we_o     (up_buf_we),
    .up_buf_addr_o   (up_buf_addr),
    .up_buf_data_o   (up_buf_data)
  );

  rm_save_route #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_save (
    .up_buf_we_i    (up_buf_we),
    .up_buf_addr_i  (up_buf_addr),
    .up_buf_data_i  (up_buf_data),
    .sv_valid_i     (sv_valid_i),
    .sv_ready_o     (sv_ready_o),
    .sv_to_mem_i    (sv_to_mem_i),
    .sv_addr_i      (sv_addr_i),
    .sv_data_i      (sv_data_i),
    .buf_we_o       (buf_we_o),
    .buf_addr_o     (buf_addr_o),
    .buf_wdata_o    (buf_wdata_o),
    .mem_wr_valid_o (mem_wr_valid_o),
    .mem_wr_ready_i (mem_wr_ready_i),
    .mem_wr_addr_o  (mem_wr_addr_o),
    .mem_wr_data_o  (mem_wr_data_o)
  );

endmodule

// File: rtl/ring_mover_chk.sv
module ring_mover_chk #(
  parameter int NCORE  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NCORE-1:0]  rd_req_i,
  input logic [NCORE-1:0]  rd_gnt_o,
  input logic              mem_rd_valid_o,
  input logic              mem_rd_ready_i,
  input logic [ADDR_W-1:0] mem_rd_addr_o,
  input logic              mem_rsp_valid_i,
  input logic              mem_rsp_ready_o,
  input logic [NCORE-1:0]  core_valid_o,
  input logic              sv_valid_i,
  input logic              sv_ready_o,
  input logic              sv_to_mem_i,
  input logic [DATA_W-1:0] sv_data_i,
  input logic              buf_we_o,
  input logic [DATA_W-1:0] buf_wdata_o,
  input logic              up_valid_i,
  input logic              up_ready_o,
  input logic              dn_valid_o,
  input logic              dn_ready_i
);

  p_gnt_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_gnt_o & ~rd_req_i) == '0);

  p_gnt_issue_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rd_gnt_o) |=> mem_rd_valid_o);

  p_single_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_valid_o && mem_rd_ready_i) |=> (!mem_rd_valid_o && rd_gnt_o == '0));

  p_issue_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_valid_o && !mem_rd_ready_i) |=> (mem_rd_valid_o && $stable(mem_rd_addr_o)));

  p_rsp_bcast_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rsp_valid_i && mem_rsp_ready_o) |-> (core_valid_o != '0));

  p_stall_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && !up_ready_o) |-> (dn_valid_o && !dn_ready_i && core_valid_o == '0));

  p_save_buf_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sv_valid_i && !sv_to_mem_i && sv_ready_o) |-> (buf_we_o && buf_wdata_o == sv_data_i));

endmodule

bind ring_mover ring_mover_chk #(
  .NCORE (NCORE),
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .rd_req_i        (rd_req_i),
  .rd_gnt_o        (rd_gnt_o),
  .mem_rd_valid_o  (mem_rd_valid_o),
  .mem_rd_ready_i  (mem_rd_ready_i),
  .mem_rd_addr_o   (mem_rd_addr_o),
  .mem_rsp_valid_i (mem_rsp_valid_i),
  .mem_rsp_ready_o (mem_rsp_ready_o),
  .core_valid_o    (core_valid_o),
  .sv_valid_i      (sv_valid_i),
  .sv_ready_o      (sv_ready_o),
  .sv_to_mem_i     (sv_to_mem_i),
  .sv_data_i       (sv_data_i),
  .buf_we_o        (buf_we_o),
  .buf_wdata_o     (buf_wdata_o),
  .up_valid_i      (up_valid_i),
  .up_ready_o      (up_ready_o),
  .dn_valid_o      (dn_valid_o),
  .dn_ready_i      (dn_ready_i)
);

// File: tb/sim_ring_mover.sv
module sim_ring_mover;
  localparam int NC  = 4;
  localparam int GW  = 3;
  localparam int AW  = 8;
  localparam int LW  = 4;
  localparam int DW  = 16;
  localparam int GID = 2;
  localparam int FW  = 2 + GW + AW + DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NC-1:0]    rd_req, rd_gnt, core_valid;
  logic [NC*AW-1:0] rd_addr;
  logic [NC*LW-1:0] rd_len;
  logic             mem_rd_valid, mem_rd_ready, mem_rsp_valid, mem_rsp_ready, mem_rsp_last;
  logic [AW-1:0]    mem_rd_addr, sv_addr, buf_addr, mem_wr_addr;
  logic [LW-1:0]    mem_rd_len;
  logic [DW-1:0]    mem_rsp_data, core_data, sv_data, buf_wdata, mem_wr_data;
  logic             sv_valid, sv_ready, sv_to_mem, buf_we, mem_wr_valid, mem_wr_ready;
  logic             up_valid, up_ready, dn_valid, dn_ready;
  logic [FW-1:0]    up_frame, dn_frame;

  ring_mover #(.NCORE(NC), .GID_W(GW), .ADDR_W(AW), .LEN_W(LW), .DATA_W(DW),
               .GROUP_ID(GID)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_req_i(rd_req), .rd_addr_i(rd_addr), .rd_len_i(rd_len), .rd_gnt_o(rd_gnt),
    .mem_rd_valid_o(mem_rd_valid), .mem_rd_ready_i(mem_rd_ready),
    .mem_rd_addr_o(mem_rd_addr), .mem_rd_len_o(mem_rd_len),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_ready_o(mem_rsp_ready),
    .mem_rsp_data_i(mem_rsp_data), .mem_rsp_last_i(mem_rsp_last),
    .core_valid_o(core_valid), .core_data_o(core_data),
    .sv_valid_i(sv_valid), .sv_ready_o(sv_ready), .sv_to_mem_i(sv_to_mem),
    .sv_addr_i(sv_addr), .sv_data_i(sv_data),
    .buf_we_o(buf_we), .buf_addr_o(buf_addr), .buf_wdata_o(buf_wdata),
    .mem_wr_valid_o(mem_wr_valid), .mem_wr_ready_i(mem_wr_ready),
    .mem_wr_addr_o(mem_wr_addr), .mem_wr_data_o(mem_wr_data),
    .up_valid_i(up_valid), .up_ready_o(up_ready), .up_frame_i(up_frame),
    .dn_valid_o(dn_valid), .dn_ready_i(dn_ready), .dn_frame_o(dn_frame)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [AW-1:0] ra [NC];
  logic [LW-1:0] rl [NC];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] mk(input logic [1:0] k, input logic [GW-1:0] d,
                                       input logic [AW-1:0] t, input logic [DW-1:0] p);
    return {k, d, t, p};
  endfunction

  function automatic int leader(input logic [NC-1:0] req);
    for (int i = 0; i < NC; i++) if (req[i]) return i;
    return 0;
  endfunction

  function automatic logic [NC-1:0] exp_merge(input logic [NC-1:0] req);
    logic [NC-1:0] m = '0;
    int ld = leader(req);
    for (int i = 0; i < NC; i++)
      if (req[i] && ra[i] == ra[ld] && rl[i] == rl[ld]) m[i] = 1'b1;
    return m;
  endfunction

  task automatic load_req();
    for (int i = 0; i < NC; i++) begin
      rd_addr[i*AW +: AW] = ra[i];
      rd_len[i*LW +: LW]  = rl[i];
    end
  endtask

  // called at a negedge with no read outstanding
  task automatic run_read(input logic [NC-1:0] req);
    logic [NC-1:0] em;
    int ld, nb;
    load_req();
    rd_req = req;
    em = exp_merge(req);
    ld = leader(req);
    #1;
    chk("R2/R3 grant mask", 32'(rd_gnt), 32'(em));
    @(negedge clk);
    #1;
    chk("R5 no grant while busy", 32'(rd_gnt), 32'd0);
    chk("R2 read offered", 32'(mem_rd_valid), 32'd1);
    chk("R2 read address", 32'(mem_rd_addr), 32'(ra[ld]));
    chk("R2 read length", 32'(mem_rd_len), 32'(rl[ld]));
    @(negedge clk);
    rd_req = '0;
    #1;
    chk("R5 single read", 32'(mem_rd_valid), 32'd0);
    nb = 1 + int'($urandom % 3);
    for (int b = 0; b < nb; b++) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = DW'($urandom);
      mem_rsp_last  = (b == nb - 1);
      #1;
      chk("R4 broadcast mask", 32'(core_valid), 32'(em));
      chk("R4 broadcast data", 32'(core_data), 32'(mem_rsp_data));
      chk("R1 no forward while disabled", 32'(dn_valid), 32'd0);
      @(negedge clk);
    end
    mem_rsp_valid = 1'b0;
    mem_rsp_last  = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [1:0] k;
    logic [GW-1:0] d;
    logic [AW-1:0] t;
    logic [DW-1:0] p;
    logic mine, fwd, loc, sav, rdy;
    void'($urandom(32'd1234));
    rd_req = '0; rd_addr = '0; rd_len = '0;
    mem_rd_ready = 1'b1; mem_rsp_valid = 1'b0; mem_rsp_data = '0; mem_rsp_last = 1'b0;
    sv_valid = 1'b0; sv_to_mem = 1'b0; sv_addr = '0; sv_data = '0; mem_wr_ready = 1'b1;
    up_valid = 1'b0; up_frame = '0; dn_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 reset read idle", 32'(mem_rd_valid), 32'd0);
    chk("R1 reset link idle", 32'(dn_valid), 32'd0);
    chk("R1 reset cores idle", 32'(core_valid), 32'd0);
    chk("R1 reset up ready", 32'(up_ready), 32'd1);
    @(negedge clk);

    // R2/R3 directed: core 2 differs in address
    ra = '{8'h10, 8'h10, 8'h20, 8'h10};
    rl = '{4'd2, 4'd2, 4'd2, 4'd2};
    run_read(4'b1111);
    run_read(4'b0100);  // R3 late grant of the odd core
    // R2 length must match too
    ra = '{8'h30, 8'h30, 8'h30, 8'h30};
    rl = '{4'd1, 4'd3, 4'd1, 4'd1};
    run_read(4'b1111);
    run_read(4'b0010);

    // random merges
    for (int it = 0; it < 30; it++) begin
      logic [NC-1:0] rq;
      for (int i = 0; i < NC; i++) begin
        ra[i] = 8'h40 + AW'($urandom % 3);
        rl[i] = 4'd1 + LW'($urandom % 2);
      end
      rq = NC'($urandom);
      if (rq == '0) rq = 4'b1000;
      run_read(rq);
    end

    // R11: upstream wins the core bus during a response
    ra[0] = 8'h55; rl[0] = 4'd1;
    load_req();
    rd_req = 4'b0001;
    @(negedge clk);
    rd_req = '0;
    @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_data = 16'hAAAA; mem_rsp_last = 1'b1;
    up_valid = 1'b1; up_frame = mk(2'd0, 3'(GID), 8'h05, 16'h1234);
    #1;
    chk("R11 response held", 32'(mem_rsp_ready), 32'd0);
    chk("R11 upstream data", 32'(core_data), 32'h1234);
    chk("R7 load to all cores", 32'(core_valid), 32'hF);
    @(negedge clk);
    up_valid = 1'b0;
    #1;
    chk("R11 response resumes", 32'(mem_rsp_ready), 32'd1);
    chk("R4 held beat mask", 32'(core_valid), 32'h1);
    chk("R4 held beat data", 32'(core_data), 32'hAAAA);
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_last = 1'b0;

    // R8 directed stall
    up_valid = 1'b1; up_frame = mk(2'd2, 3'd5, 8'h11, 16'h0F0F); dn_ready = 1'b0;
    #1;
    chk("R8 stall up_ready", 32'(up_ready), 32'd0);
    chk("R8 stall no local", 32'(core_valid), 32'd0);
    chk("R8 stall frame offered", 32'(dn_frame), 32'(mk(2'd2, 3'd5, 8'h11, 16'h0F0F)));
    @(negedge clk);
    dn_ready = 1'b1;
    #1;
    chk("R8 release up_ready", 32'(up_ready), 32'd1);
    chk("R8 release local", 32'(core_valid), 32'hF);
    @(negedge clk);
    up_valid = 1'b0;

    // random upstream frames (R6, R7, R8, R9)
    for (int it = 0; it < 40; it++) begin
      k = 2'($urandom); d = GW'($urandom % 4); t = AW'($urandom); p = DW'($urandom);
      if (k == 2'd3 && d == 3'(GID)) k = 2'd0;
      rdy = 1'($urandom);
      mine = (d == 3'(GID));
      fwd  = !mine;
      loc  = (k == 2'd0 && mine) || k == 2'd2;
      sav  = (k == 2'd1) && mine;
      up_valid = 1'b1; up_frame = mk(k, d, t, p); dn_ready = rdy;
      #1;
      chk("R8 up_ready", 32'(up_ready), 32'(!fwd || rdy));
      chk("R7 forward decision", 32'(dn_valid), 32'(fwd));
      if (fwd) chk("R6 frame unchanged", 32'(dn_frame), 32'(mk(k, d, t, p)));
      chk("R7 local delivery", 32'(core_valid), (loc && (!fwd || rdy)) ? 32'hF : 32'd0);
      if (loc && (!fwd || rdy)) chk("R6 payload field", 32'(core_data), 32'(p));
      chk("R9 buffer write", 32'(buf_we), 32'(sav));
      if (sav) begin
        chk("R9 buffer addr from tag", 32'(buf_addr), 32'(t));
        chk("R9 buffer data", 32'(buf_wdata), 32'(p));
      end
      @(negedge clk);
      up_valid = 1'b0; dn_ready = 1'b1;
    end

    // R9 core saves
    sv_valid = 1'b1; sv_to_mem = 1'b1; sv_addr = 8'h21; sv_data = 16'hC0DE;
    #1;
    chk("R9 mem write valid", 32'(mem_wr_valid), 32'd1);
    chk("R9 mem write addr", 32'(mem_wr_addr), 32'h21);
    chk("R9 mem write data", 32'(mem_wr_data), 32'hC0DE);
    chk("R9 no buffer write", 32'(buf_we), 32'd0);
    @(negedge clk);
    mem_wr_ready = 1'b0;
    #1;
    chk("R9 mem backpressure", 32'(sv_ready), 32'd0);
    @(negedge clk);
    mem_wr_ready = 1'b1; sv_to_mem = 1'b0;
    #1;
    chk("R9 buffer save", 32'(buf_we), 32'd1);
    chk("R9 buffer save data", 32'(buf_wdata), 32'hC0DE);
    chk("R9 no mem write", 32'(mem_wr_valid), 32'd0);
    @(negedge clk);
    up_valid = 1'b1; up_frame = mk(2'd1, 3'(GID), 8'h77, 16'h5A5A);
    #1;
    chk("R9 link save wins", 32'(buf_wdata), 32'h5A5A);
    chk("R9 core save held", 32'(sv_ready), 32'd0);
    @(negedge clk);
    up_valid = 1'b0; sv_valid = 1'b0;

    // R10 enable forwarding of read data to group 5
    up_valid = 1'b1; up_frame = mk(2'd3, 3'(GID), 8'h00, 16'd11);
    #1;
    chk("R10 config consumed", 32'(dn_valid), 32'd0);
    chk("R10 config not delivered", 32'(core_valid), 32'd0);
    @(negedge clk);
    up_valid = 1'b0;
    ra[1] = 8'h33; rl[1] = 4'd1;
    load_req();
    rd_req = 4'b0010;
    @(negedge clk);
    rd_req = '0;
    @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_data = 16'hBEEF; mem_rsp_last = 1'b1; dn_ready = 1'b0;
    #1;
    chk("R10 forward offered", 32'(dn_valid), 32'd1);
    chk("R10 forward frame", 32'(dn_frame), 32'(mk(2'd2, 3'd5, 8'h33, 16'hBEEF)));
    chk("R10 beat held", 32'(mem_rsp_ready), 32'd0);
    chk("R10 no local while held", 32'(core_valid), 32'd0);
    @(negedge clk);
    dn_ready = 1'b1;
    #1;
    chk("R10 beat accepted", 32'(mem_rsp_ready), 32'd1);
    chk("R10 local with forward", 32'(core_valid), 32'h2);
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_last = 1'b0;
    #1;
    chk("R5 read closed", 32'(mem_rd_valid), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule